// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block decides whether a synthesizer is frequency-locked. It compares the edge rate of the synthesizer's divided output against a reference clock. Both signals arrive as raw levels. Each passes through a synchronizer into one system clock, and the block counts the rising edges that come out. Before it can judge lock, the block has to learn how the two rates relate. The reference runs at one of five power-of-two ratios to the divided output, and no pin names the ratio. So the block counts divided-output edges over a short run of reference periods. It rounds that count to a power of two and keeps the result as the divider exponent for every later comparison.

Once the ratio is known, the block counts divided-output edges over a long gate of reference periods. It compares the count with the value an exact lock would give. It raises the loss-of-lock flag at a wide deviation and drops it only at a narrower one, so the flag does not chatter near the limit. A hold input from the power-down sequencer keeps the flag low and restarts the whole sequence when it is released.

The controller has four states:
- `ST_HOLD`: the block is parked.
- `ST_ALIGN`: the block waits for a reference edge to open a window.
- `ST_DETECT`: a short window measures the ratio.
- `ST_MEASURE`: a long window checks the frequency.

The transitions are:
- any state → `ST_HOLD` while `hold_i` is high.
- `ST_HOLD` → `ST_ALIGN` when `hold_i` is low.
- `ST_ALIGN` → `ST_DETECT` on a reference edge.
- `ST_DETECT` → `ST_MEASURE` at the end of a window whose ratio is allowed. After a window with a disallowed ratio, the block stays in `ST_DETECT` and starts a new window.
- `ST_MEASURE` → `ST_DETECT` at the end of a window that leaves the flag high. After a window that leaves the flag low, the block stays in `ST_MEASURE`.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is applied, `lol_o` is 0, `ratio_ok_o` is 0 and `ratio_o` is 0.
- R2: While `hold_i` is high, `lol_o` is 0 in the same cycle. From the next clock edge on, `ratio_ok_o` is 0, whatever the input frequencies are.
- R3: One cycle after `hold_i` falls, `lol_o` is 1. It stays 1 through ratio detection and until a measurement window ends inside the release band.
- R4: A window is a span of reference periods that opens and closes on reference rising edges. Ratio detection counts the divided-output rising edges inside a window of 2^DET_LOG reference periods. It takes the exponent e as (index of the highest set bit of the count) − DET_LOG, plus 1 when the bit just below that one is set. The allowed base is 0 when `rate_sel_i` is 0 and 2 when it is 1. When e lies in [base, base+4], `ratio_ok_o` becomes 1 and `ratio_o` becomes e − base.
- R5: When the detected exponent lies outside [base, base+4], or the count is zero, `ratio_ok_o` is 0, `lol_o` stays 1, and detection repeats.
- R6: A measurement window spans 2^GATE_LOG reference periods. The exact count is 2^(GATE_LOG+e). Let LOSS_BASE = floor(2^GATE_LOG · LOSS_PPM / 10^6). While `lol_o` is 0, a window whose count differs from the exact count by at least LOSS_BASE·2^e sets `lol_o` to 1.
- R7: Let LOCK_BASE = floor(2^GATE_LOG · LOCK_PPM / 10^6). While `lol_o` is 1, a measurement window whose deviation is below LOCK_BASE·2^e clears `lol_o`.
- R8: A deviation in [LOCK_BASE·2^e, LOSS_BASE·2^e) leaves `lol_o` unchanged in either state.
- R9: The ratio and lock results do not depend on the phase of the reference relative to the divided output, including a half-period (180°) offset.
- R10: `ratio_o` does not change while the block stays in measurement, and `lol_o` falls only at the end of a measurement window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock. It must run faster than twice the highest counted edge rate. |
| rst_ni | input | 1 | Asynchronous active-low reset. |
| hold_i | input | 1 | Power-down/calibrate hold, synchronous to `clk_i`. |
| rate_sel_i | input | 1 | Band select. It picks the allowed exponent range: base 0 or base 2. |
| vco_div_i | input | 1 | Divided synthesizer clock, asynchronous level. |
| ref_i | input | 1 | Reference clock, asynchronous level. |
| lol_o | output | 1 | Loss-of-lock flag. |
| ratio_o | output | 3 | Detected ratio code, 0..4. |
| ratio_ok_o | output | 1 | The last detection produced an allowed ratio. |

## Verification
The assertions assume two things about the inputs. First, each input level holds for at least one system clock, so every edge reaches the counters exactly once. Second, `hold_i` changes only in step with the system clock. The stimulus meets both assumptions. It drives the divided output from a phase accumulator with a period of four or eight system clocks, and the reference from a divider of at least four clocks. All inputs change on the falling clock edge. The frequency offsets are chosen well clear of the threshold boundaries, so the ±1 edge of quantization never decides a check. Reference phase offsets, including half a period, are drawn at random or set directly.

// File: rtl/fld_pkg.sv
package fld_pkg;
    typedef enum logic [1:0] {
        ST_HOLD,
        ST_ALIGN,
        ST_DETECT,
        ST_MEASURE
    } fld_state_e;
endpackage

// File: rtl/fld_edge_sync.sv
module fld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0], lvl_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fld_ratio_snap.sv
module fld_ratio_snap #(
    parameter int CW      = 21,
    parameter int DET_LOG = 4,
    parameter int BASE_LO = 0,
    parameter int BASE_HI = 2,
    parameter int EW      = 3
) (
    input  logic [CW-1:0] cnt_i,
    input  logic          sat_i,
    input  logic          rate_sel_i,
    output logic          ok_o,
    output logic [2:0]    code_o,
    output logic [EW-1:0] exp_o
);
    int   msb;
    int   e;
    int   base;
    logic rnd;

    always_comb begin
        msb = -1;
        rnd = 1'b0;
        for (int i = 0; i < CW; i++) begin
            if (cnt_i[i]) begin
                msb = i;
                rnd = (i > 0) ? cnt_i[(i > 0) ? i - 1 : 0] : 1'b0;
            end
        end
        base   = rate_sel_i ? BASE_HI : BASE_LO;
        e      = msb - DET_LOG + int'(rnd);
        ok_o   = !sat_i && (msb >= 0) && (e >= base) && (e <= base + 4);
        code_o = ok_o ? 3'(e - base) : 3'd0;
        exp_o  = ok_o ? EW'(e) : '0;
    end
endmodule

// File: rtl/fld_dev_cmp.sv
module fld_dev_cmp #(
    parameter int CW       = 21,
    parameter int GATE_LOG = 13,
    parameter int LOSS_PPM = 600,
    parameter int LOCK_PPM = 300,
    parameter int EW       = 3
) (
    input  logic [CW-1:0] cnt_i,
    input  logic          sat_i,
    input  logic [EW-1:0] exp_i,
    output logic          far_o,
    output logic          near_o
);
    localparam longint LOSS_BASE = ((longint'(1) << GATE_LOG) * LOSS_PPM) / 1000000;
    localparam longint LOCK_BASE = ((longint'(1) << GATE_LOG) * LOCK_PPM) / 1000000;
    localparam logic [CW-1:0] LOSS_LIM0 = CW'(LOSS_BASE);
    localparam logic [CW-1:0] LOCK_LIM0 = CW'(LOCK_BASE);

    logic [CW-1:0] target;
    logic [CW-1:0] dev;
    logic [CW-1:0] loss_lim;
    logic [CW-1:0] lock_lim;

    always_comb begin
        target   = {{(CW-1){1'b0}}, 1'b1} << (GATE_LOG + int'(exp_i));
        dev      = (cnt_i >= target) ? (cnt_i - target) : (target - cnt_i);
        loss_lim = LOSS_LIM0 << exp_i;
        lock_lim = LOCK_LIM0 << exp_i;
        far_o    = sat_i || (dev >= loss_lim);
        near_o   = !sat_i && (dev < lock_lim);
    end
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
    import fld_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GATE_LOG    = 13,
    parameter int DET_LOG     = 4,
    parameter int LOSS_PPM    = 600,
    parameter int LOCK_PPM    = 300,
    parameter int BASE_LO     = 0,
    parameter int BASE_HI     = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hold_i,
    input  logic       rate_sel_i,
    input  logic       vco_div_i,
    input  logic       ref_i,
    output logic       lol_o,
    output logic [2:0] ratio_o,
    output logic       ratio_ok_o
);
    localparam int MAX_EXP = ((BASE_HI > BASE_LO) ? BASE_HI : BASE_LO) + 4;
    localparam int CW      = GATE_LOG + MAX_EXP + 2;
    localparam int RW      = GATE_LOG + 1;
    localparam int EW      = $clog2(MAX_EXP + 1);
    localparam logic [RW-1:0] DET_LAST  = RW'((1 << DET_LOG) - 1);
    localparam logic [RW-1:0] MEAS_LAST = RW'((1 << GATE_LOG) - 1);

    fld_state_e    state_q, state_d;
    logic [RW-1:0] ref_cnt_q;
    logic [CW-1:0] vco_cnt_q;
    logic          sat_q;
    logic          lol_q, ok_q;
    logic [2:0]    code_q;
    logic [EW-1:0] exp_q;

    logic          vco_rise, ref_rise;
    logic          snap_ok;
    logic [2:0]    snap_code;
    logic [EW-1:0] snap_exp;
    logic          cmp_far, cmp_near;
    logic          win_end, lol_next;

    fld_edge_sync #(.STAGES(SYNC_STAGES)) u_vco_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(vco_div_i), .rise_o(vco_rise));
    fld_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ref_i), .rise_o(ref_rise));

    fld_ratio_snap #(.CW(CW), .DET_LOG(DET_LOG), .BASE_LO(BASE_LO),
                     .BASE_HI(BASE_HI), .EW(EW)) u_snap (
        .cnt_i(vco_cnt_q), .sat_i(sat_q), .rate_sel_i(rate_sel_i),
        .ok_o(snap_ok), .code_o(snap_code), .exp_o(snap_exp));

    fld_dev_cmp #(.CW(CW), .GATE_LOG(GATE_LOG), .LOSS_PPM(LOSS_PPM),
                  .LOCK_PPM(LOCK_PPM), .EW(EW)) u_cmp (
        .cnt_i(vco_cnt_q), .sat_i(sat_q), .exp_i(exp_q),
        .far_o(cmp_far), .near_o(cmp_near));

    assign win_end  = ref_rise &&
                      (((state_q == ST_DETECT)  && (ref_cnt_q == DET_LAST)) ||
                       ((state_q == ST_MEASURE) && (ref_cnt_q == MEAS_LAST)));
    assign lol_next = lol_q ? !cmp_near : cmp_far;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (hold_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:    state_d = ST_ALIGN;
                ST_ALIGN:   if (ref_rise) state_d = ST_DETECT;
                ST_DETECT:  if (win_end && snap_ok) state_d = ST_MEASURE;
                ST_MEASURE: if (win_end && lol_next) state_d = ST_DETECT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    // counters and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lol_q     <= 1'b0;
            ok_q      <= 1'b0;
            code_q    <= '0;
            exp_q     <= '0;
            ref_cnt_q <= '0;
            vco_cnt_q <= '0;
            sat_q     <= 1'b0;
        end else if (hold_i) begin
            lol_q     <= 1'b0;
            ok_q      <= 1'b0;
            ref_cnt_q <= '0;
            vco_cnt_q <= '0;
            sat_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    lol_q     <= 1'b1;
                    ref_cnt_q <= '0;
                    vco_cnt_q <= '0;
                    sat_q     <= 1'b0;
                end
                ST_ALIGN: begin
                    if (ref_rise) begin
                        ref_cnt_q <= '0;
                        vco_cnt_q <= CW'(vco_rise);
                        sat_q     <= 1'b0;
                    end
                end
                ST_DETECT, ST_MEASURE: begin
                    if (win_end) begin
                        ref_cnt_q <= '0;
                        vco_cnt_q <= CW'(vco_rise);
                        sat_q     <= 1'b0;
                        if (state_q == ST_DETECT) begin
                            ok_q <= snap_ok;
                            if (snap_ok) begin
                                code_q <= snap_code;
                                exp_q  <= snap_exp;
                            end else begin
                                lol_q <= 1'b1;
                            end
                        end else begin
                            lol_q <= lol_next;
                        end
                    end else begin
                        if (ref_rise) ref_cnt_q <= ref_cnt_q + 1'b1;
                        if (vco_rise) begin
                            if (&vco_cnt_q) sat_q <= 1'b1;
                            else            vco_cnt_q <= vco_cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign lol_o      = lol_q & ~hold_i;
    assign ratio_o    = code_q;
    assign ratio_ok_o = ok_q;

    AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (!lol_q && !ok_q)); // R2
    AST_ALIGN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ALIGN) |-> lol_q); // R3
    AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ok_q |-> (code_q <= 3'd4)); // R4
    AST_LOCK_NEEDS_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lol_q && state_q == ST_MEASURE) |-> ok_q); // R5
    AST_BANDS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmp_far && cmp_near)); // R8
    AST_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MEASURE && $past(state_q) == ST_MEASURE) |-> $stable(code_q)); // R10
    AST_RELEASE_AT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(lol_q) && !$past(hold_i)) |-> ($past(state_q) == ST_MEASURE)); // R10
endmodule

// File: tb/sim_freq_lock_det.sv
`timescale 1ns/1ps
module sim_freq_lock_det;
    localparam int GATE_LOG = 8;
    localparam int DET_LOG  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold = 1'b1;
    logic rate_sel = 1'b0;
    logic lol;
    logic [2:0] ratio;
    logic ratio_ok;

    int unsigned acc = 0;
    int unsigned inc = 0;
    int rc = 0;
    int rp = 4;
    int ph = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic vco_lvl, ref_lvl;
    assign vco_lvl = acc[31];
    assign ref_lvl = (((rc + ph) % rp) < (rp / 2));

    always #10 clk = ~clk;

    always @(negedge clk) begin
        acc <= acc + inc;
        rc  <= (rc + 1 >= rp) ? 0 : rc + 1;
    end

    freq_lock_det #(.GATE_LOG(GATE_LOG), .DET_LOG(DET_LOG),
                    .LOSS_PPM(40000), .LOCK_PPM(20000)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .rate_sel_i(rate_sel),
        .vco_div_i(vco_lvl), .ref_i(ref_lvl),
        .lol_o(lol), .ratio_o(ratio), .ratio_ok_o(ratio_ok));

    function automatic int base_of(input bit rs);
        return rs ? 2 : 0;
    endfunction
    function automatic int exp_ok(input int m, input bit rs);
        return (m >= base_of(rs) && m <= base_of(rs) + 4) ? 1 : 0;
    endfunction
    function automatic int exp_code(input int m, input bit rs);
        return exp_ok(m, rs) ? m - base_of(rs) : 0;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic stim(input int m, input int ppm, input int phase);
        longint b;
        b   = (m >= 0) ? (longint'(1) << 30) : (longint'(1) << 29);
        inc = 32'(b + (b * ppm) / 1000000);
        rp  = (m >= 0) ? (4 << m) : 4;
        ph  = phase;
    endtask

    task automatic relaunch(input bit rs, input int m, input int ppm, input int phase);
        hold = 1'b1;
        wait_cyc(3);
        rate_sel = rs;
        stim(m, ppm, phase);
        wait_cyc(3);
        hold = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(17);
        stim(0, 0, 0);
        wait_cyc(5);
        check("R1 lol in reset", int'(lol), 0);
        check("R1 ratio_ok in reset", int'(ratio_ok), 0);
        check("R1 ratio in reset", int'(ratio), 0);
        rst_n = 1'b1;
        wait_cyc(3);

        // lock at nominal, then walk through hysteresis bands (m=0)
        hold = 1'b0;
        wait_cyc(2);
        check("R3 lol after hold release", int'(lol), 1);
        wait_cyc(3000);
        check("R7 locked at nominal", int'(lol), 0);
        check("R4 ratio_ok m=0", int'(ratio_ok), 1);
        check("R4 ratio m=0", int'(ratio), 0);
        stim(0, 30000, 0);
        wait_cyc(3000);
        check("R8 stays locked at 3%", int'(lol), 0);
        stim(0, 60000, 0);
        wait_cyc(3000);
        check("R6 loss at +6%", int'(lol), 1);
        stim(0, 30000, 0);
        wait_cyc(3000);
        check("R8 stays lost at 3%", int'(lol), 1);
        stim(0, 10000, 0);
        wait_cyc(3000);
        check("R7 release at 1%", int'(lol), 0);
        stim(0, -60000, 0);
        wait_cyc(3000);
        check("R6 loss at -6%", int'(lol), 1);

        // hold while badly off frequency
        hold = 1'b1;
        #1;
        check("R2 lol low same cycle", int'(lol), 0);
        wait_cyc(1);
        check("R2 ratio_ok cleared", int'(ratio_ok), 0);
        wait_cyc(2000);
        check("R2 lol low during hold", int'(lol), 0);

        // phase independence at m=1
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : ((k == 1) ? 4 : 3);
            relaunch(1'b0, 1, 0, p);
            wait_cyc(5000);
            check("R9 ratio vs phase", int'(ratio), 1);
            check("R9 lock vs phase", int'(lol), 0);
        end

        // directed band edges
        relaunch(1'b1, 0, 0, 0);
        wait_cyc(200);
        check("R5 below band ok", int'(ratio_ok), 0);
        check("R5 below band lol", int'(lol), 1);
        relaunch(1'b0, 5, 0, 0);
        wait_cyc(1300 + 20);
        check("R5 above band ok", int'(ratio_ok), 0);
        check("R5 above band lol", int'(lol), 1);
        relaunch(1'b1, 6, 0, 0);
        wait_cyc(2600 + 20);
        check("R4 top code band1 ok", int'(ratio_ok), 1);
        check("R4 top code band1", int'(ratio), 4);
        relaunch(1'b0, 4, 0, 0);
        wait_cyc(660 + 20);
        check("R4 top code band0", int'(ratio), 4);

        // constrained random trials
        for (int t = 0; t < 6; t++) begin
            bit rs;
            int m, ppm, p, wdet;
            rs  = 1'($urandom_range(1, 0));
            m   = int'($urandom_range(7, 0)) - 1;
            ppm = int'($urandom_range(20000, 0)) - 10000;
            p   = int'($urandom_range(255, 0));
            relaunch(rs, m, ppm, p);
            wdet = 10 * ((m >= 0) ? (4 << m) : 4) + 20;
            wait_cyc(wdet);
            check("R4 random ratio_ok", int'(ratio_ok), exp_ok(m, rs));
            check("R4 random ratio", exp_ok(m, rs) ? int'(ratio) : 0, exp_code(m, rs));
            if (exp_ok(m, rs) == 0) check("R5 random lol", int'(lol), 1);
            if (exp_ok(m, rs) == 1 && m <= 2) begin
                wait_cyc(2 * (1 << (GATE_LOG + m)) * 4 + 200);
                check("R7 random lock", int'(lol), 0);
            end
        end

        finish_run();
    end
endmodule